// File: doc/BRIEF.md
# H-Bridge Commutation Sequencer

This block turns a handful of supply, control and sense flags into the four gate commands of a full bridge: high-left, high-right, low-left and low-right. The analog parts of a bridge driver (supply comparators, the oscillator, level shifters and slope detectors) are assumed to sit outside. Each of them reaches the block as a single digital bit. The drive clock and the two slope-complete flags are asynchronous and pass through synchronisers. The supply flags, the disable and the run-enable inputs are sampled directly in the block's clock domain.

While the supply is not yet qualified, the block holds both low sides on and both high sides off, so that the bootstrap capacitors can charge. The supply is qualified with hysteresis between a release flag and a lower reset flag. Once the supply is qualified and the run-enable input is high, the bridge conducts on one diagonal at a time. In divider mode the bridge always starts on the left-high diagonal and swaps diagonals on every falling edge of the drive input. In bypass mode the drive level picks the diagonal directly.

Every change of diagonal passes through a gap in which all four commands are off. The gap lasts at least a minimum number of cycles and is stretched until the slope-complete flag of the leg whose low side is about to turn on has pulsed. A timeout closes the gap if that pulse never arrives. A disable input overrides everything and turns all four commands off.

Top module: `hb_commutator`

## Requirements
- R1: After reset, while the supply is not qualified and disable is low, the outputs are {hl,hr,ll,lr} = 0011 (both low sides on, both high sides off). While reset is held, all four outputs are 0.
- R2: A high on the release flag qualifies the supply. A high on the reset flag drops qualification, and the reset flag wins if both flags are high. While both flags are low, qualification keeps its previous value.
- R3: Disable high forces all four outputs to 0 from the next clock edge, whatever the state (start-up, gap or conducting).
- R4: With the supply qualified and disable low, run-enable low holds the pattern 0011.
- R5: In divider mode (bypass low), the first conducting state after start-up, after disable, or after run-enable rises is always diagonal A = 1001 (hl and lr on).
- R6: In divider mode each synchronised falling edge of the drive input swaps between diagonal A (1001) and diagonal B (0110). A rising edge changes nothing, so high-left turns on once for every two falling edges.
- R7: In bypass mode the conducting diagonal follows the drive level: a high level gives B = 0110 and a low level gives A = 1001.
- R8: On every change of diagonal, and on entry from start-up, all outputs are 0 for at least MIN_GAP cycles. When switching toward A the gap also waits for a rising pulse on the right slope flag; when switching toward B it waits for a rising pulse on the left slope flag. A pulse on the other leg's flag does not end the gap. The gap that follows start-up does not wait for a slope pulse.
- R9: If the required slope pulse never arrives, the gap ends after exactly GAP_TMO cycles.
- R10: In divider mode, a falling drive edge that arrives during a gap is held back and carried out after that gap, so two quick falling edges return the bridge to the diagonal it started on.
- R11: A high side and the low side of the same leg are never on together, and the bridge never goes from one high side on to the other high side on in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_rel_i | input | 1 | Supply above the release level |
| sup_low_i | input | 1 | Supply below the reset level |
| bridge_off_i | input | 1 | Disable: all gates off |
| run_en_i | input | 1 | Start-up delay release; low holds the charge pattern |
| div_bypass_i | input | 1 | High: follow the drive level; low: divide by two on falling edges |
| drive_i | input | 1 | Asynchronous drive clock |
| slope_l_i | input | 1 | Left half-bridge slope-complete pulse (asynchronous) |
| slope_r_i | input | 1 | Right half-bridge slope-complete pulse (asynchronous) |
| gate_hl_o | output | 1 | High-left gate command |
| gate_hr_o | output | 1 | High-right gate command |
| gate_ll_o | output | 1 | Low-left gate command |
| gate_lr_o | output | 1 | Low-right gate command |

## Verification
The bench sweeps every combination of disable, run-enable, mode, drive level and supply state, and compares the settled outputs with the pattern each combination should produce. A design that let run-enable or the supply state beat disable would show 0011 where 0000 is expected. A design that started on the wrong diagonal would show 0110 in divider mode. The bench measures gap lengths in cycles for three cases: the minimum, a gap stretched by a late slope pulse on the correct leg after an early pulse on the wrong leg, and the timeout. A design that sensed the wrong leg would close the gap early, and one with an off-by-one counter would be a cycle out. The bench also counts high-left turn-ons over ten drive periods and sends two falling edges in quick succession. A design that toggled on rising edges would count double, and one that dropped a request arriving during a gap would stop on the opposite diagonal.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_GAP, PH_ON} phase_e;

  typedef struct packed {
    logic hl;
    logic hr;
    logic ll;
    logic lr;
  } gates_t;

  localparam gates_t GATES_OFF  = 4'b0000;
  localparam gates_t GATES_LOWS = 4'b0011;
  localparam gates_t GATES_A    = 4'b1001;
  localparam gates_t GATES_B    = 4'b0110;

  function automatic gates_t diag_gates(input logic sel_b);
    return sel_b ? GATES_B : GATES_A;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES < 2) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/hb_supply.sv
module hb_supply (
  input  logic clk,
  input  logic rst,
  input  logic rel_i,
  input  logic low_i,
  output logic ok_o
);
  always_ff @(posedge clk) begin
    if (rst)        ok_o <= 1'b0;
    else if (low_i) ok_o <= 1'b0;
    else if (rel_i) ok_o <= 1'b1;
  end

  // R2: with neither flag high, qualification keeps its value
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!rel_i && !low_i) |=> $stable(ok_o));
  // R2: the reset flag drops qualification, winning over the release flag
  a_r2_drop: assert property (@(posedge clk) disable iff (rst)
    low_i |=> !ok_o);
endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
  parameter int MIN_GAP = 12,
  parameter int GAP_TMO = 64,
  localparam int CW = $clog2(GAP_TMO + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic need_i,
  input  logic run_i,
  input  logic slope_i,
  output logic done_o
);
  logic [CW-1:0] cnt;
  logic          seen;
  logic          need_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt    <= '0;
      seen   <= 1'b0;
      need_q <= rst ? 1'b0 : need_i;
    end else if (run_i) begin
      if (cnt != CW'(GAP_TMO)) cnt <= cnt + 1'b1;
      seen <= seen | slope_i;
    end
  end

  assign done_o = run_i && (cnt >= CW'(MIN_GAP - 1)) &&
                  (!need_q || seen || slope_i || (cnt >= CW'(GAP_TMO - 1)));

  // R9: the gap counter never runs past the timeout
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run_i |-> (cnt < CW'(GAP_TMO)));
endmodule

// File: rtl/hb_commutator.sv
module hb_commutator #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 12,
  parameter int GAP_TMO     = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic sup_rel_i,
  input  logic sup_low_i,
  input  logic bridge_off_i,
  input  logic run_en_i,
  input  logic div_bypass_i,
  input  logic drive_i,
  input  logic slope_l_i,
  input  logic slope_r_i,
  output logic gate_hl_o,
  output logic gate_hr_o,
  output logic gate_ll_o,
  output logic gate_lr_o
);
  import hb_pkg::*;

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn, syn_q;
  logic drv_s, fall, slope_l_rise, slope_r_rise;
  logic sup_ok, run_ok, gap_done, gap_start, gap_need;
  phase_e ph_q, ph_n;
  logic   tgt_q, tgt_n, pend_q, pend_n;
  gates_t g_q, g_n;

  assign raw_in = {drive_i, slope_l_i, slope_r_i};

  hb_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) syn_q <= '0;
    else     syn_q <= syn;
  end

  assign drv_s        = syn[2];
  assign fall         = syn_q[2] & ~syn[2];
  assign slope_l_rise = syn[1] & ~syn_q[1];
  assign slope_r_rise = syn[0] & ~syn_q[0];

  hb_supply u_supply (
    .clk(clk), .rst(rst), .rel_i(sup_rel_i), .low_i(sup_low_i), .ok_o(sup_ok)
  );

  // toward A the right node falls (right low side turns on); toward B the left
  hb_gap_timer #(.MIN_GAP(MIN_GAP), .GAP_TMO(GAP_TMO)) u_gap (
    .clk(clk), .rst(rst), .start_i(gap_start), .need_i(gap_need),
    .run_i(ph_q == PH_GAP),
    .slope_i(tgt_q ? slope_l_rise : slope_r_rise),
    .done_o(gap_done)
  );

  assign run_ok = sup_ok && !bridge_off_i && run_en_i;

  always_comb begin
    ph_n      = ph_q;
    tgt_n     = tgt_q;
    pend_n    = pend_q;
    g_n       = g_q;
    gap_start = 1'b0;
    gap_need  = 1'b1;
    if (!run_ok) begin
      ph_n   = PH_IDLE;
      pend_n = 1'b0;
      g_n    = bridge_off_i ? GATES_OFF : GATES_LOWS;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_n      = PH_GAP;
          gap_start = 1'b1;
          gap_need  = 1'b0;
          tgt_n     = div_bypass_i ? drv_s : 1'b0;
          pend_n    = 1'b0;
          g_n       = GATES_OFF;
        end
        PH_GAP: begin
          g_n = GATES_OFF;
          if (fall && !div_bypass_i) pend_n = 1'b1;
          if (gap_done) begin
            ph_n = PH_ON;
            g_n  = diag_gates(tgt_q);
          end
        end
        default: begin
          g_n = diag_gates(tgt_q);
          if (div_bypass_i) pend_n = 1'b0;
          if (div_bypass_i ? (drv_s != tgt_q) : (fall || pend_q)) begin
            ph_n      = PH_GAP;
            gap_start = 1'b1;
            tgt_n     = div_bypass_i ? drv_s : ~tgt_q;
            pend_n    = 1'b0;
            g_n       = GATES_OFF;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      tgt_q  <= 1'b0;
      pend_q <= 1'b0;
      g_q    <= GATES_OFF;
    end else begin
      ph_q   <= ph_n;
      tgt_q  <= tgt_n;
      pend_q <= pend_n;
      g_q    <= g_n;
    end
  end

  assign gate_hl_o = g_q.hl;
  assign gate_hr_o = g_q.hr;
  assign gate_ll_o = g_q.ll;
  assign gate_lr_o = g_q.lr;

  // R11: no leg ever has both of its switches commanded on
  a_r11_no_shoot: assert property (@(posedge clk) disable iff (rst)
    !(gate_hl_o && gate_ll_o) && !(gate_hr_o && gate_lr_o));
  // R11: one high side never hands over directly to the other
  a_r11_hl_to_hr: assert property (@(posedge clk) disable iff (rst)
    $past(gate_hl_o) |-> !gate_hr_o);
  a_r11_hr_to_hl: assert property (@(posedge clk) disable iff (rst)
    $past(gate_hr_o) |-> !gate_hl_o);
  // R3: disable clears every gate on the next edge
  a_r3_disable_off: assert property (@(posedge clk) disable iff (rst)
    bridge_off_i |=> !(gate_hl_o || gate_hr_o || gate_ll_o || gate_lr_o));
  // R1: unqualified supply gives the charge pattern
  a_r1_charge: assert property (@(posedge clk) disable iff (rst)
    (!sup_ok && !bridge_off_i) |=> (gate_ll_o && gate_lr_o && !gate_hl_o && !gate_hr_o));
  // R4: run-enable low holds the charge pattern
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_en_i && !bridge_off_i) |=> (gate_ll_o && gate_lr_o && !gate_hl_o && !gate_hr_o));
endmodule

// File: tb/hb_commutator_tb.sv
module hb_commutator_tb_top;
  localparam int MIN_GAP = 12;
  localparam int GAP_TMO = 64;
  localparam logic [3:0] P_OFF = 4'b0000, P_LOWS = 4'b0011,
                         P_A = 4'b1001, P_B = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sup_rel = 0, sup_low = 0, boff = 0, run_en = 0, bypass = 0;
  logic drv = 0, sl_l = 0, sl_r = 0;
  logic hl, hr, ll, lr;
  int   n_tests = 0, n_fail = 0, cyc = 0;
  bit   auto_sl = 1'b0;
  int   auto_cnt = 0;
  bit   mon_en = 1'b0;
  logic hl_prev = 1'b0;
  int   hl_rises = 0;

  always #4 clk = ~clk;

  hb_commutator #(.SYNC_STAGES(2), .MIN_GAP(MIN_GAP), .GAP_TMO(GAP_TMO)) dut_i (
    .clk(clk), .rst(rst), .sup_rel_i(sup_rel), .sup_low_i(sup_low),
    .bridge_off_i(boff), .run_en_i(run_en), .div_bypass_i(bypass),
    .drive_i(drv), .slope_l_i(sl_l), .slope_r_i(sl_r),
    .gate_hl_o(hl), .gate_hr_o(hr), .gate_ll_o(ll), .gate_lr_o(lr)
  );

  wire [3:0] outs = {hl, hr, ll, lr};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
    if (auto_sl) begin
      if (outs == P_OFF) begin
        auto_cnt <= auto_cnt + 1;
        if (auto_cnt == 3) begin sl_l <= 1; sl_r <= 1; end
        if (auto_cnt == 5) begin sl_l <= 0; sl_r <= 0; end
      end else begin
        auto_cnt <= 0; sl_l <= 0; sl_r <= 0;
      end
    end
    if (mon_en && hl && !hl_prev) hl_rises <= hl_rises + 1;
    hl_prev <= hl;
  end

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_int(input string req, input int got, input int lo, input int hi);
    n_tests++;
    if (got < lo || got > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic measure_gap(output int len);
    int guard = 0;
    while (outs != P_OFF && guard < 200) begin @(negedge clk); guard++; end
    len = 0;
    while (outs == P_OFF && len < 300) begin len++; @(negedge clk); end
  endtask

  task automatic set_supply(input bit ok);
    if (ok) sup_rel = 1; else sup_low = 1;
    cyc_wait(2);
    sup_rel = 0; sup_low = 0;
  endtask

  initial begin
    int glen;
    cyc_wait(3);
    chk("R1 reset all off", outs, P_OFF);
    rst = 0;
    cyc_wait(5);
    chk("R1 charge pattern before release", outs, P_LOWS);

    // R2 hysteresis with divider mode start (R5 after start-up)
    auto_sl = 1; run_en = 1;
    set_supply(1);
    cyc_wait(40);
    chk("R2 release qualifies / R5 start on A", outs, P_A);
    cyc_wait(30);
    chk("R2 hold between thresholds", outs, P_A);
    set_supply(0);
    cyc_wait(5);
    chk("R2 reset flag drops to charge", outs, P_LOWS);
    cyc_wait(30);
    chk("R2 stays dropped between thresholds", outs, P_LOWS);
    sup_rel = 1; sup_low = 1; cyc_wait(3); sup_rel = 0; sup_low = 0; cyc_wait(20);
    chk("R2 reset flag wins over release", outs, P_LOWS);
    set_supply(1);

    // R8 gap from start-up entry is the minimum
    measure_gap(glen);
    chk_int("R8 start-up entry gap", glen, MIN_GAP, MIN_GAP);
    cyc_wait(20);

    // R5 after delayed start
    run_en = 0; cyc_wait(10);
    chk("R4 run-enable low holds charge", outs, P_LOWS);
    run_en = 1; cyc_wait(40);
    chk("R5 start on A after run-enable", outs, P_A);

    // R3 disable during a gap
    drv = 1; cyc_wait(10); drv = 0;
    cyc_wait(6);
    boff = 1; cyc_wait(2);
    chk("R3 disable during gap", outs, P_OFF);
    boff = 0; cyc_wait(40);
    chk("R5 start on A after disable", outs, P_A);

    // R6 divider count over ten drive periods
    hl_rises = 0; mon_en = 1;
    for (int i = 0; i < 10; i++) begin
      drv = 1; cyc_wait(40); drv = 0; cyc_wait(40);
    end
    mon_en = 0;
    chk_int("R6 high-left turn-ons per falling edges", hl_rises, 5, 5);
    chk("R6 even number of swaps ends on A", outs, P_A);
    drv = 1; cyc_wait(40);
    chk("R6 rising edge no effect", outs, P_A);
    drv = 0; cyc_wait(40);
    chk("R6 falling edge swaps to B", outs, P_B);
    drv = 1; cyc_wait(40);
    chk("R6 rising edge leaves B", outs, P_B);
    drv = 0; cyc_wait(40);
    chk("R6 falling edge swaps back to A", outs, P_A);

    // R10 second falling edge inside the gap is queued
    drv = 1; cyc_wait(20); drv = 0;
    cyc_wait(6);
    chk("R10 in gap after first edge", outs, P_OFF);
    drv = 1; cyc_wait(2); drv = 0;
    cyc_wait(100);
    chk("R10 queued edge returns to A", outs, P_A);

    // R7 bypass mode follows the level
    bypass = 1; cyc_wait(40);
    chk("R7 low level gives A", outs, P_A);
    drv = 1; cyc_wait(40);
    chk("R7 high level gives B", outs, P_B);
    drv = 0; cyc_wait(40);
    chk("R7 low level back to A", outs, P_A);

    // R8 stretched gap: wrong leg early, right leg late (toward B waits left)
    auto_sl = 0; sl_l = 0; sl_r = 0; cyc_wait(2);
    drv = 1;
    fork
      measure_gap(glen);
      begin
        while (outs != P_OFF) @(negedge clk);
        cyc_wait(9);  sl_r = 1; cyc_wait(2); sl_r = 0;
        cyc_wait(19); sl_l = 1; cyc_wait(2); sl_l = 0;
      end
    join
    chk_int("R8 gap stretched by left slope only", glen, 31, 36);
    cyc_wait(10);
    chk("R8 lands on B", outs, P_B);

    // R8 minimum with early correct pulse (toward A waits right)
    drv = 0;
    fork
      measure_gap(glen);
      begin
        while (outs != P_OFF) @(negedge clk);
        cyc_wait(2); sl_r = 1; cyc_wait(2); sl_r = 0;
      end
    join
    chk_int("R8 minimum gap with early slope", glen, MIN_GAP, MIN_GAP);

    // R9 timeout without slope
    cyc_wait(10);
    drv = 1;
    measure_gap(glen);
    chk_int("R9 timeout gap length", glen, GAP_TMO, GAP_TMO);
    cyc_wait(5);
    chk("R9 lands on B after timeout", outs, P_B);
    auto_sl = 1;

    // R3/R4/R5/R7 sweep of static combinations
    for (int c = 0; c < 32; c++) begin
      logic [3:0] exp;
      bit s_ok, s_off, s_run, s_byp, s_drv;
      {s_ok, s_off, s_run, s_byp, s_drv} = 5'(c);
      boff = 1; cyc_wait(2);
      set_supply(s_ok);
      bypass = s_byp; drv = s_drv; run_en = s_run;
      cyc_wait(6);
      boff = s_off;
      cyc_wait(40);
      if (s_off)                 exp = P_OFF;
      else if (!s_ok || !s_run)  exp = P_LOWS;
      else if (s_byp)            exp = s_drv ? P_B : P_A;
      else                       exp = P_A;
      chk($sformatf("R3 R4 R5 R7 sweep case %0d", c), outs, exp);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule